// File: doc/BRIEF.md
# Scope-Tagged Cache Request Router

This block is the control decision point of one cache level in a multi-level hierarchy. Every request that reaches the level carries a scope tag naming how far out in the hierarchy the operation has to become visible. The router compares that tag with the scope level configured for this cache. Where this cache sits at or beyond the requested scope, the request finishes here. Otherwise it is passed downstream and only acknowledged upstream once the next level reports completion.

Maintenance requests (invalidate, write-back, and write-back followed by invalidate) carry a scope tag too. They touch this cache only when the cache sits strictly inside their scope. Only one request is handled at a time, so a maintenance request can never pass an earlier operation, and no later operation can pass it. The data array and the tag array sit outside this block. It drives a one-cycle local-service strobe for data operations and an invalidate-all strobe for the tag array.

Top module: `scope_fwd_ctrl`

## Requirements
- R1: After reset, req_ready is 1 and fwd_valid, up_ack, local_strobe and inv_all are all 0.
- R2: Scope codes are 0 = compute unit, 1 = shader engine, 2 = device, 3 = system, and cfg_level uses the same codes. A read (op 0), write (op 1) or read-modify-write (op 2) whose scope is at most cfg_level is serviced here. In the cycle after acceptance, local_strobe and up_ack are both 1 and nothing is forwarded.
- R3: A request with op 0 to 5 whose scope exceeds cfg_level is forwarded. fwd_valid rises in the cycle after acceptance, with fwd_op, fwd_scope and fwd_addr equal to the accepted values. It stays asserted, with stable fields, until fwd_ready is seen.
- R4: For a forwarded request, up_ack stays 0 until fwd_ack is sampled. It is 1 in the same cycle as fwd_ack.
- R5: An invalidate (op 3) with scope above cfg_level pulses inv_all together with its up_ack. With scope at most cfg_level it is acknowledged in the cycle after acceptance, with no inv_all and no local_strobe.
- R6: A write-back (op 4) with scope above cfg_level is acknowledged only by the downstream acknowledge and never pulses inv_all. With a smaller or equal scope it is acknowledged locally with no strobes.
- R7: A write-back-plus-invalidate (op 5) with scope above cfg_level pulses inv_all only in the cycle in which fwd_ack returns. inv_all comes together with up_ack, so the write-back has completed before anything is invalidated.
- R8: Only one request is in flight. req_ready is 0 from the edge that accepts a request until the edge after its up_ack cycle.
- R9: fwd_ack asserted while no forwarded request is waiting causes no up_ack and no inv_all.
- R10: Op codes 6 and 7 are acknowledged in the cycle after acceptance with no local_strobe, no forward and no inv_all, whatever the scope.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_level | input | 2 | Scope level of this cache |
| req_valid | input | 1 | Upstream request present |
| req_ready | output | 1 | Router can accept a request |
| req_op | input | 3 | Operation code |
| req_scope | input | 2 | Request scope tag |
| req_addr | input | ADDR_W | Request address |
| fwd_valid | output | 1 | Forwarded request present |
| fwd_ready | input | 1 | Downstream takes the forwarded request |
| fwd_op | output | 3 | Forwarded operation code |
| fwd_scope | output | 2 | Forwarded scope tag |
| fwd_addr | output | ADDR_W | Forwarded address |
| fwd_ack | input | 1 | Downstream completion |
| local_strobe | output | 1 | Service the data operation in this cache |
| up_ack | output | 1 | Completion back to upstream |
| inv_all | output | 1 | Invalidate every line of this cache |

## Verification
A wrong scope comparison shows in the first cycle after acceptance, because fwd_valid and local_strobe are swapped at the ports. A latched field that gets corrupted shows as a mismatch on fwd_op, fwd_scope or fwd_addr in that same cycle. A state register stuck in the waiting state shows as req_ready staying low after the downstream acknowledge. A state that leaves waiting too early shows as an up_ack before fwd_ack. An invalidate decision on the wrong side of the scope boundary shows as an inv_all pulse, or a missing one, in the completion cycle.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  localparam int OP_W = 3;
  localparam int SC_W = 2;

  localparam logic [OP_W-1:0] OP_RD    = 3'd0;
  localparam logic [OP_W-1:0] OP_WR    = 3'd1;
  localparam logic [OP_W-1:0] OP_RMW   = 3'd2;
  localparam logic [OP_W-1:0] OP_INV   = 3'd3;
  localparam logic [OP_W-1:0] OP_WB    = 3'd4;
  localparam logic [OP_W-1:0] OP_WBINV = 3'd5;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOCAL = 2'd1,
    ST_SEND  = 2'd2,
    ST_WAIT  = 2'd3
  } st_e;
endpackage

// File: rtl/sfc_decide.sv
module sfc_decide
  import sfc_pkg::*;
(
  input  logic [OP_W-1:0] op,
  input  logic [SC_W-1:0] scope,
  input  logic [SC_W-1:0] level,
  output logic            go_fwd,
  output logic            data_op,
  output logic            inv_op
);
  logic known_op;

  always_comb begin
    known_op = (op <= OP_WBINV);
    data_op  = (op == OP_RD) || (op == OP_WR) || (op == OP_RMW);
    inv_op   = (op == OP_INV) || (op == OP_WBINV);
    go_fwd   = known_op && (scope > level);
  end
endmodule

// File: rtl/sfc_hold.sv
module sfc_hold
  import sfc_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [OP_W-1:0]   op_in,
  input  logic [SC_W-1:0]   scope_in,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              data_in,
  input  logic              inv_in,
  output logic [OP_W-1:0]   op_q,
  output logic [SC_W-1:0]   scope_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic              data_q,
  output logic              inv_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q    <= '0;
      scope_q <= '0;
      addr_q  <= '0;
      data_q  <= 1'b0;
      inv_q   <= 1'b0;
    end else if (load) begin
      op_q    <= op_in;
      scope_q <= scope_in;
      addr_q  <= addr_in;
      data_q  <= data_in;
      inv_q   <= inv_in;
    end
  end
endmodule

// File: rtl/sfc_fsm.sv
module sfc_fsm
  import sfc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic go_fwd,
  input  logic fwd_ready,
  input  logic fwd_ack,
  input  logic data_q,
  input  logic inv_q,
  output logic accept,
  output logic req_ready,
  output logic fwd_valid,
  output logic local_strobe,
  output logic up_ack,
  output logic inv_all
);
  st_e state_q, state_d;

  always_comb begin
    state_d      = state_q;
    req_ready    = (state_q == ST_IDLE);
    accept       = req_ready && req_valid;
    fwd_valid    = (state_q == ST_SEND);
    local_strobe = 1'b0;
    up_ack       = 1'b0;
    inv_all      = 1'b0;
    case (state_q)
      ST_IDLE: if (accept) state_d = go_fwd ? ST_SEND : ST_LOCAL;
      ST_LOCAL: begin
        up_ack       = 1'b1;
        local_strobe = data_q;
        state_d      = ST_IDLE;
      end
      ST_SEND: if (fwd_ready) state_d = ST_WAIT;
      ST_WAIT: if (fwd_ack) begin
        up_ack  = 1'b1;
        inv_all = inv_q;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/scope_fwd_ctrl.sv
module scope_fwd_ctrl
  import sfc_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_level,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_op,
  input  logic [1:0]        req_scope,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              fwd_valid,
  input  logic              fwd_ready,
  output logic [2:0]        fwd_op,
  output logic [1:0]        fwd_scope,
  output logic [ADDR_W-1:0] fwd_addr,
  input  logic              fwd_ack,
  output logic              local_strobe,
  output logic              up_ack,
  output logic              inv_all
);
  logic go_fwd, data_op, inv_op, accept, data_q, inv_q;

  sfc_decide u_decide (
    .op     (req_op),
    .scope  (req_scope),
    .level  (cfg_level),
    .go_fwd (go_fwd),
    .data_op(data_op),
    .inv_op (inv_op)
  );

  sfc_hold #(.ADDR_W(ADDR_W)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept),
    .op_in   (req_op),
    .scope_in(req_scope),
    .addr_in (req_addr),
    .data_in (data_op),
    .inv_in  (inv_op),
    .op_q    (fwd_op),
    .scope_q (fwd_scope),
    .addr_q  (fwd_addr),
    .data_q  (data_q),
    .inv_q   (inv_q)
  );

  sfc_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .go_fwd      (go_fwd),
    .fwd_ready   (fwd_ready),
    .fwd_ack     (fwd_ack),
    .data_q      (data_q),
    .inv_q       (inv_q),
    .accept      (accept),
    .req_ready   (req_ready),
    .fwd_valid   (fwd_valid),
    .local_strobe(local_strobe),
    .up_ack      (up_ack),
    .inv_all     (inv_all)
  );
endmodule

// File: rtl/scope_fwd_ctrl_chk.sv
module scope_fwd_ctrl_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        cfg_level,
  input logic              req_ready,
  input logic              fwd_valid,
  input logic              fwd_ready,
  input logic [2:0]        fwd_op,
  input logic [1:0]        fwd_scope,
  input logic [ADDR_W-1:0] fwd_addr,
  input logic              local_strobe,
  input logic              up_ack,
  input logic              inv_all
);
  // R3
  fwd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid && !fwd_ready |=> fwd_valid && $stable(fwd_addr) && $stable(fwd_op) && $stable(fwd_scope));
  // R3
  fwd_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> fwd_scope > cfg_level);
  // R2
  local_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    local_strobe |-> up_ack && !fwd_valid);
  // R7
  inv_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |-> up_ack);
  // R8
  single_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_valid || up_ack) |-> !req_ready);
  // R4
  no_early_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> !up_ack);
endmodule

bind scope_fwd_ctrl scope_fwd_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_level   (cfg_level),
  .req_ready   (req_ready),
  .fwd_valid   (fwd_valid),
  .fwd_ready   (fwd_ready),
  .fwd_op      (fwd_op),
  .fwd_scope   (fwd_scope),
  .fwd_addr    (fwd_addr),
  .local_strobe(local_strobe),
  .up_ack      (up_ack),
  .inv_all     (inv_all)
);

// File: tb/scope_fwd_ctrl_bench.sv
`timescale 1ns/1ps
module scope_fwd_ctrl_bench;
  localparam int AW = 32;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] cfg_level = 2'd0;
  logic req_valid = 1'b0, fwd_ready = 1'b0, fwd_ack = 1'b0;
  logic [2:0] req_op = 3'd0;
  logic [1:0] req_scope = 2'd0;
  logic [AW-1:0] req_addr = '0;
  logic req_ready, fwd_valid, local_strobe, up_ack, inv_all;
  logic [2:0] fwd_op;
  logic [1:0] fwd_scope;
  logic [AW-1:0] fwd_addr;
  int checks = 0, errors = 0, cycles = 0;

  always #10 clk = ~clk;

  scope_fwd_ctrl #(.ADDR_W(AW)) u_scope_fwd_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_level(cfg_level),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_scope(req_scope), .req_addr(req_addr),
    .fwd_valid(fwd_valid), .fwd_ready(fwd_ready), .fwd_op(fwd_op),
    .fwd_scope(fwd_scope), .fwd_addr(fwd_addr), .fwd_ack(fwd_ack),
    .local_strobe(local_strobe), .up_ack(up_ack), .inv_all(inv_all)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog actual %0d expected below 100000", cycles);
      finish_run();
    end
  end

  // One whole transaction; expectations derived from the requirement text.
  task automatic run_txn(input logic [2:0] op, input logic [1:0] sc,
                         input logic [1:0] lvl, input logic [AW-1:0] a,
                         input int hold_cycles);
    logic exp_fwd, exp_data, exp_inv;
    exp_fwd  = (op <= 3'd5) && (sc > lvl);
    exp_data = (op <= 3'd2);
    exp_inv  = exp_fwd && (op == 3'd3 || op == 3'd5);
    @(negedge clk);
    cfg_level = lvl; req_op = op; req_scope = sc; req_addr = a; req_valid = 1'b1;
    #1 chk("R8 ready before accept", req_ready, 1'b1);
    @(negedge clk);
    req_valid = 1'b0;
    if (!exp_fwd) begin
      chk(op > 3'd5 ? "R10 up_ack" : "R2 local up_ack", up_ack, 1'b1);
      chk(op > 3'd5 ? "R10 local_strobe" : "R2 local_strobe", local_strobe, exp_data);
      chk("R2 no forward", fwd_valid, 1'b0);
      chk(op == 3'd3 ? "R5 no inv_all local" : "R6 no inv_all local", inv_all, 1'b0);
      chk("R8 busy in ack cycle", req_ready, 1'b0);
    end else begin
      chk("R3 fwd_valid", fwd_valid, 1'b1);
      chk("R3 fwd_op", fwd_op, op);
      chk("R3 fwd_scope", fwd_scope, sc);
      chk("R3 fwd_addr", fwd_addr, a);
      chk("R2 no local_strobe when forwarded", local_strobe, 1'b0);
      for (int i = 0; i < hold_cycles; i++) begin
        @(negedge clk);
        chk("R3 fwd held", fwd_valid, 1'b1);
        chk("R3 addr held", fwd_addr, a);
      end
      fwd_ready = 1'b1;
      @(negedge clk);
      fwd_ready = 1'b0;
      chk("R3 fwd dropped after ready", fwd_valid, 1'b0);
      chk("R4 no ack before fwd_ack", up_ack, 1'b0);
      chk("R8 busy while waiting", req_ready, 1'b0);
      @(negedge clk);
      chk("R4 still waiting", up_ack, 1'b0);
      chk(op == 3'd5 ? "R7 no early inv_all" : "R5 no early inv_all", inv_all, 1'b0);
      fwd_ack = 1'b1;
      #1;
      chk("R4 ack with fwd_ack", up_ack, 1'b1);
      chk(op == 3'd4 ? "R6 wb no inv" : (op == 3'd5 ? "R7 inv_all" : "R5 inv_all"),
          inv_all, exp_inv);
    end
    @(negedge clk);
    fwd_ack = 1'b0;
    #1 chk("R8 ready after ack", req_ready, 1'b1);
    chk("R4 ack is one cycle", up_ack, 1'b0);
  endtask

  task automatic test_reset();
    #1;
    chk("R1 req_ready", req_ready, 1'b1);
    chk("R1 fwd_valid", fwd_valid, 1'b0);
    chk("R1 up_ack", up_ack, 1'b0);
    chk("R1 local_strobe", local_strobe, 1'b0);
    chk("R1 inv_all", inv_all, 1'b0);
  endtask

  task automatic test_local_data();
    run_txn(3'd0, 2'd0, 2'd0, 32'h1000, 0);
    run_txn(3'd1, 2'd1, 2'd2, 32'h2004, 0);
    run_txn(3'd2, 2'd3, 2'd3, 32'h3008, 0);
  endtask

  task automatic test_forward_data();
    run_txn(3'd0, 2'd1, 2'd0, 32'hA000_0010, 0);
    run_txn(3'd1, 2'd3, 2'd2, 32'hB000_0020, 2);
    run_txn(3'd2, 2'd2, 2'd1, 32'hC000_0030, 1);
  endtask

  task automatic test_maintenance();
    run_txn(3'd3, 2'd2, 2'd1, 32'h0000_0040, 0); // R5 forwarded invalidate
    run_txn(3'd3, 2'd1, 2'd1, 32'h0000_0044, 0); // R5 equal scope, local
    run_txn(3'd4, 2'd3, 2'd0, 32'h0000_0048, 1); // R6 forwarded write-back
    run_txn(3'd4, 2'd0, 2'd2, 32'h0000_004C, 0); // R6 local write-back
    run_txn(3'd5, 2'd3, 2'd2, 32'h0000_0050, 3); // R7 forwarded wbinv
    run_txn(3'd5, 2'd2, 2'd3, 32'h0000_0054, 0); // R7 local wbinv, no inv
  endtask

  task automatic test_stray_ack();
    @(negedge clk);
    fwd_ack = 1'b1;
    #1;
    chk("R9 stray ack no up_ack", up_ack, 1'b0);
    chk("R9 stray ack no inv_all", inv_all, 1'b0);
    @(negedge clk);
    fwd_ack = 1'b0;
    chk("R9 still ready", req_ready, 1'b1);
  endtask

  task automatic test_reserved_ops();
    run_txn(3'd6, 2'd3, 2'd0, 32'h0000_0060, 0); // R10
    run_txn(3'd7, 2'd2, 2'd1, 32'h0000_0064, 0); // R10
  endtask

  initial begin
    repeat (2) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_local_data();
    test_forward_data();
    test_maintenance();
    test_stray_ack();
    test_reserved_ops();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule